// File: doc/BRIEF.md
# I2C Master Quarter-Step Bit Engine

This block drives the two open-drain lines of an I2C bus for a single master. It takes one command at a time over a valid/ready handshake. A command is one of: bus clear, start condition, stop condition, byte write or byte read. A read also carries the acknowledge level the master returns. Each command is played out as a fixed series of quarter-period steps. A quarter lasts `quarterDiv + 1` clock cycles. When the last quarter ends, a one-cycle `done` pulse is raised. The received byte and the acknowledge bit sampled from the slave are then valid on the outputs.

Both line outputs use open-drain meaning: 1 releases the line and 0 pulls it low. The bus level of SDA comes back through a two-flop synchronizer. Building transactions from these commands (addressing, repeated starts, byte counts) is left to the logic that issues them. The engine never samples SCL, so a slave cannot stretch the clock.

Top module: `i2c_quarter_engine`

## Requirements
- R1: During and right after reset, `sclOut` and `sdaOut` are 1 (released), `cmdReady` is 1, `done` is 0, `ackSampled` is 1 and `rdData` is 0.
- R2: A quarter lasts `quarterDiv+1` cycles. `done` is high for exactly one cycle. If the accepting edge is A, `done` is high in the cycle after edge A + N*(`quarterDiv`+1). N is 40 for a clear, 4 for a start, 4 for a stop, 37 for a write, 29 for a read and 1 for an unused code.
- R3: Command codes on `cmdOp` are: 0 bus clear, 1 start, 2 stop, 3 write, 4 read. Codes 5 to 7 complete after one quarter and do not change either line.
- R4: A bus clear keeps SDA released while it gives 9 SCL pulses. Each pulse is 2 quarters low and then 2 quarters high. A stop follows. This makes 10 SCL rises, and the only SDA change while SCL is high is the final rise of the stop.
- R5: A start changes SDA exactly once while SCL is high, a fall, and ends with SCL high and SDA low. A stop drops SCL, pulls SDA low, releases SCL and then releases SDA. It gives one SCL rise and exactly one SDA change while SCL is high, a rise. Both lines end released.
- R6: A write sends `cmdData` MSB first over 8 SCL pulses. On each bit, SCL is low for 2 quarters with the bit placed after the first, then high for 2 quarters. SDA changes only while SCL is low. On the 9th pulse SDA is released.
- R7: On a write, `ackSampled` takes the synchronized SDA level at the end of the second high quarter of the 9th pulse: 0 means acknowledge, 1 means no acknowledge. Other commands leave it unchanged.
- R8: A read releases SDA and clocks 8 pulses, each 1 quarter low and 2 quarters high. At the end of the first high quarter the engine samples SDA. The samples form `rdData`, first sample in bit 7. SDA does not change while SCL is high.
- R9: After the 8 read bits, the engine drives SDA to `cmdAckLvl` for the 9th pulse. The pulse is low for 2 quarters, high for 2 quarters, and ends with a low quarter.
- R10: `cmdReady` is low from the accepting edge until `done`. A `cmdValid` seen while `cmdReady` is low is ignored: no extra `done` and no change to the running command. While idle with no request, the lines hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, command accepted on valid and ready |
| cmdOp | input | 3 | Command code |
| cmdData | input | 8 | Byte to send for a write |
| cmdAckLvl | input | 1 | Acknowledge level driven after a read |
| quarterDiv | input | 16 | Quarter period minus one, in clock cycles |
| done | output | 1 | One-cycle end-of-command pulse |
| rdData | output | 8 | Last byte read |
| ackSampled | output | 1 | Acknowledge sampled on the last write |
| sclOut | output | 1 | SCL enable, 1 released, 0 low |
| sdaOut | output | 1 | SDA enable, 1 released, 0 low |
| sdaIn | input | 1 | SDA bus level |

## Verification
Each command's `done` is due exactly N*(`quarterDiv`+1) edges after the accepting edge. The bench stores that due cycle with the expected results when it sees acceptance, and compares the cycle count when `done` appears. All sampling and line-edge counting happen on the falling clock edge, half a cycle after the registered outputs move, so every SCL rise and SDA change is counted in the cycle it occurs. The model slave changes SDA only on SCL falls. That leaves at least two quarters before the engine samples, which is more than the two synchronizer stages need at the divider values used.

// File: rtl/i2c_quarter_pkg.sv
package i2c_quarter_pkg;
  localparam int BYTE_W      = 8;
  localparam int OP_W        = 3;
  localparam int CLR_PULSES  = 9;
  localparam int SYNC_STAGES = 2;
  localparam int QTR_W       = 3;
  localparam int BIT_W       = $clog2(CLR_PULSES);

  localparam logic [OP_W-1:0] OP_CLEAR = OP_W'(0);
  localparam logic [OP_W-1:0] OP_START = OP_W'(1);
  localparam logic [OP_W-1:0] OP_STOP  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_WRITE = OP_W'(3);
  localparam logic [OP_W-1:0] OP_READ  = OP_W'(4);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_STA, ST_STO, ST_WBIT, ST_WACK, ST_RBIT, ST_RACK, ST_NOP
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic run;
    logic sclLow;
    logic sclRel;
    logic sdaLow;
    logic sdaRel;
    logic sdaBit;
    logic sdaAck;
    logic shiftTx;
    logic sampleRd;
    logic sampleAck;
  } dpCtl_t;
endpackage

// File: rtl/i2c_quarter_ctrl.sv
module i2c_quarter_ctrl
  import i2c_quarter_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  input  logic            tick,
  output logic            cmdReady,
  output logic            done,
  output dpCtl_t          ctl,
  output engState_t       stOut
);
  localparam logic [QTR_W-1:0] Q0 = QTR_W'(0);
  localparam logic [QTR_W-1:0] Q1 = QTR_W'(1);
  localparam logic [QTR_W-1:0] Q2 = QTR_W'(2);
  localparam logic [QTR_W-1:0] Q3 = QTR_W'(3);
  localparam logic [QTR_W-1:0] Q4 = QTR_W'(4);
  localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] CLR_LAST  = BIT_W'(CLR_PULSES - 1);

  engState_t        stQ, stNxt;
  logic [QTR_W-1:0] qtrQ, qtrNxt;
  logic [BIT_W-1:0] bitQ, bitNxt;
  logic             accept, enter, finish;

  function automatic logic [QTR_W-1:0] lastQuarter(engState_t s);
    case (s)
      ST_WACK, ST_RACK: return Q4;
      ST_RBIT:          return Q2;
      ST_NOP:           return Q0;
      default:          return Q3;
    endcase
  endfunction

  function automatic engState_t opState(logic [OP_W-1:0] op);
    case (op)
      OP_CLEAR: return ST_CLR;
      OP_START: return ST_STA;
      OP_STOP:  return ST_STO;
      OP_WRITE: return ST_WBIT;
      OP_READ:  return ST_RBIT;
      default:  return ST_NOP;
    endcase
  endfunction

  assign accept = cmdValid && (stQ == ST_IDLE);

  always_comb begin
    stNxt  = stQ;
    qtrNxt = qtrQ;
    bitNxt = bitQ;
    enter  = 1'b0;
    finish = 1'b0;
    if (accept) begin
      stNxt  = opState(cmdOp);
      qtrNxt = Q0;
      bitNxt = '0;
      enter  = 1'b1;
    end else if (tick && stQ != ST_IDLE) begin
      if (qtrQ != lastQuarter(stQ)) begin
        qtrNxt = qtrQ + QTR_W'(1);
        enter  = 1'b1;
      end else begin
        qtrNxt = Q0;
        case (stQ)
          ST_CLR: begin
            enter = 1'b1;
            if (bitQ == CLR_LAST) stNxt = ST_STO;
            else bitNxt = bitQ + BIT_W'(1);
          end
          ST_WBIT: begin
            enter = 1'b1;
            if (bitQ == BYTE_LAST) stNxt = ST_WACK;
            else bitNxt = bitQ + BIT_W'(1);
          end
          ST_RBIT: begin
            enter = 1'b1;
            if (bitQ == BYTE_LAST) stNxt = ST_RACK;
            else bitNxt = bitQ + BIT_W'(1);
          end
          default: begin
            stNxt  = ST_IDLE;
            finish = 1'b1;
          end
        endcase
      end
    end
  end

  // line actions fire on entry to a quarter; samples on the tick that ends one
  always_comb begin
    ctl      = '0;
    ctl.load = accept;
    ctl.run  = (stQ != ST_IDLE);
    if (enter) begin
      case (stNxt)
        ST_CLR: begin
          if (qtrNxt == Q0) begin ctl.sclLow = 1'b1; ctl.sdaRel = 1'b1; end
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
        end
        ST_STA: begin
          if (qtrNxt == Q1) ctl.sdaRel = 1'b1;
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
          if (qtrNxt == Q3) ctl.sdaLow = 1'b1;
        end
        ST_STO: begin
          if (qtrNxt == Q0) ctl.sclLow = 1'b1;
          if (qtrNxt == Q1) ctl.sdaLow = 1'b1;
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
          if (qtrNxt == Q3) ctl.sdaRel = 1'b1;
        end
        ST_WBIT: begin
          if (qtrNxt == Q0) ctl.sclLow = 1'b1;
          if (qtrNxt == Q1) ctl.sdaBit = 1'b1;
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
        end
        ST_WACK: begin
          if (qtrNxt == Q0 || qtrNxt == Q4) ctl.sclLow = 1'b1;
          if (qtrNxt == Q1) ctl.sdaRel = 1'b1;
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
        end
        ST_RBIT: begin
          if (qtrNxt == Q0) begin ctl.sclLow = 1'b1; ctl.sdaRel = 1'b1; end
          if (qtrNxt == Q1) ctl.sclRel = 1'b1;
        end
        ST_RACK: begin
          if (qtrNxt == Q0 || qtrNxt == Q4) ctl.sclLow = 1'b1;
          if (qtrNxt == Q1) ctl.sdaAck = 1'b1;
          if (qtrNxt == Q2) ctl.sclRel = 1'b1;
        end
        default: ;
      endcase
    end
    if (tick) begin
      if (stQ == ST_WBIT && qtrQ == Q3) ctl.shiftTx   = 1'b1;
      if (stQ == ST_RBIT && qtrQ == Q1) ctl.sampleRd  = 1'b1;
      if (stQ == ST_WACK && qtrQ == Q3) ctl.sampleAck = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      qtrQ <= Q0;
      bitQ <= '0;
      done <= 1'b0;
    end else begin
      stQ  <= stNxt;
      qtrQ <= qtrNxt;
      bitQ <= bitNxt;
      done <= finish;
    end
  end

  assign cmdReady = (stQ == ST_IDLE);
  assign stOut    = stQ;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != ST_IDLE) && !tick |=> (stQ == $past(stQ)));

  p_clear_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CLR) |-> (bitQ <= CLR_LAST));
endmodule

// File: rtl/i2c_quarter_dp.sv
module i2c_quarter_dp
  import i2c_quarter_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdAckLvl,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic              sdaIn,
  output logic              tick,
  output logic              sclOut,
  output logic              sdaOut,
  output logic [BYTE_W-1:0] rdData,
  output logic              ackSampled
);
  logic [DIV_W-1:0]       prescQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sdaSync;
  logic [BYTE_W-1:0]      txShift, rxShift;
  logic                   ackLvlQ, ackFlagQ, sclQ, sdaQ;

  // quarter-period prescaler
  always_ff @(posedge clk) begin
    if (!rstN)              prescQ <= '0;
    else if (ctl.load)      prescQ <= quarterDiv;
    else if (ctl.run) begin
      if (prescQ == '0)     prescQ <= quarterDiv;
      else                  prescQ <= prescQ - DIV_W'(1);
    end
  end
  assign tick = ctl.run && (prescQ == '0);

  // bus level synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
  end
  assign sdaSync = syncQ[SYNC_STAGES-1];

  // open-drain line registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      if (ctl.sclLow)      sclQ <= 1'b0;
      else if (ctl.sclRel) sclQ <= 1'b1;
      if (ctl.sdaLow)      sdaQ <= 1'b0;
      else if (ctl.sdaRel) sdaQ <= 1'b1;
      else if (ctl.sdaBit) sdaQ <= txShift[BYTE_W-1];
      else if (ctl.sdaAck) sdaQ <= ackLvlQ;
    end
  end

  // byte shifters and acknowledge capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      ackLvlQ  <= 1'b1;
      ackFlagQ <= 1'b1;
    end else begin
      if (ctl.load) begin
        txShift <= cmdData;
        ackLvlQ <= cmdAckLvl;
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (ctl.sampleRd)  rxShift  <= {rxShift[BYTE_W-2:0], sdaSync};
      if (ctl.sampleAck) ackFlagQ <= sdaSync;
    end
  end

  assign sclOut     = sclQ;
  assign sdaOut     = sdaQ;
  assign rdData     = rxShift;
  assign ackSampled = ackFlagQ;

  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.sdaLow && ctl.sdaBit) && !(ctl.sclLow && ctl.sclRel));
endmodule

// File: rtl/i2c_quarter_engine.sv
module i2c_quarter_engine
  import i2c_quarter_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdAckLvl,
  input  logic [DIV_W-1:0]  quarterDiv,
  output logic              done,
  output logic [BYTE_W-1:0] rdData,
  output logic              ackSampled,
  output logic              sclOut,
  output logic              sdaOut,
  input  logic              sdaIn
);
  dpCtl_t    ctl;
  engState_t stNow;
  logic      tick;
  logic      inBytes;

  i2c_quarter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .tick(tick),
    .cmdReady(cmdReady), .done(done), .ctl(ctl), .stOut(stNow)
  );

  i2c_quarter_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdData(cmdData), .cmdAckLvl(cmdAckLvl),
    .quarterDiv(quarterDiv), .sdaIn(sdaIn), .tick(tick), .sclOut(sclOut),
    .sdaOut(sdaOut), .rdData(rdData), .ackSampled(ackSampled)
  );

  assign inBytes = (stNow == ST_WBIT) || (stNow == ST_RBIT);

  p_byte_sda_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inBytes && $past(inBytes) && (sdaOut != $past(sdaOut))) |-> !$past(sclOut));

  p_sample_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleRd |-> sclOut);

  p_ack_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleAck |-> (sdaOut && sclOut));

  p_clear_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stNow == ST_CLR) |-> sdaOut);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stNow == ST_IDLE) && !cmdValid |=> $stable(sclOut) && $stable(sdaOut));
endmodule

// File: tb/i2c_quarter_engine_test.sv
`timescale 1ns/100ps
module i2c_quarter_engine_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdReady;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdData = 8'd0;
  logic       cmdAckLvl = 1'b1;
  logic [15:0] quarterDiv = 16'd3;
  logic       done;
  logic [7:0] rdData;
  logic       ackSampled;
  logic       sclOut, sdaOut, sdaIn;
  logic       slaveSda = 1'b1;

  assign sdaIn = sdaOut & slaveSda;

  i2c_quarter_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdAckLvl(cmdAckLvl), .quarterDiv(quarterDiv), .done(done),
    .rdData(rdData), .ackSampled(ackSampled), .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         op;
    longint     due;
    logic [7:0] tx;
    logic [7:0] rd;
    logic       ackLvl;
    logic       ack;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  logic   accSeen = 1'b0;
  logic   ended = 1'b0;
  logic [7:0] drvSlvByte = 8'd0;
  logic       drvSlvAck = 1'b1;
  logic       lastAck = 1'b1;
  int   rises = 0, edgeHi = 0, lineChg = 0, curOp = 0;
  logic [7:0] txCap = 8'd0;
  logic ackCap = 1'b0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    accSeen <= cmdValid && cmdReady && rstN;
  end

  function automatic int quarters(int op);
    case (op)
      0: return 40;
      1: return 4;
      2: return 4;
      3: return 37;
      4: return 29;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and model slave, all on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (accSeen) begin
        exp_t e;
        e.op     = int'(cmdOp);
        e.due    = cyc + longint'(quarters(int'(cmdOp))) * (longint'(quarterDiv) + 1);
        e.tx     = cmdData;
        e.rd     = drvSlvByte;
        e.ackLvl = cmdAckLvl;
        if (cmdOp == 3'd3) lastAck = drvSlvAck;
        e.ack    = lastAck;
        sb.push_back(e);
        curOp = int'(cmdOp);
        rises = 0; edgeHi = 0; lineChg = 0; txCap = 8'd0; ackCap = 1'b0;
        slaveSda = (curOp == 4) ? drvSlvByte[7] : 1'b1;
      end
      if (sclOut != prevScl || sdaOut != prevSda) lineChg++;
      if (sdaOut != prevSda && prevScl && sclOut) edgeHi++;
      if (!prevScl && sclOut) begin
        rises++;
        if (rises <= 8) txCap = {txCap[6:0], sdaOut};
        else if (rises == 9) ackCap = sdaOut;
      end
      if (prevScl && !sclOut) begin
        if (curOp == 3)      slaveSda = (rises == 8) ? drvSlvAck : 1'b1;
        else if (curOp == 4) slaveSda = (rises < 8) ? drvSlvByte[7 - rises] : 1'b1;
        else                 slaveSda = 1'b1;
      end
      prevScl = sclOut;
      prevSda = sdaOut;
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, "R2 done latency", cyc, e.due);
          case (e.op)
            0: begin
              chk(rises == 10, "R4 clear SCL rises", rises, 10);
              chk(edgeHi == 1, "R4 clear SDA edges with SCL high", edgeHi, 1);
            end
            1: begin
              chk(edgeHi == 1, "R5 start SDA edges with SCL high", edgeHi, 1);
              chk({sclOut, sdaOut} == 2'b10, "R5 start end levels", {sclOut, sdaOut}, 2);
            end
            2: begin
              chk(rises == 1, "R5 stop SCL rises", rises, 1);
              chk(edgeHi == 1, "R5 stop SDA edges with SCL high", edgeHi, 1);
              chk({sclOut, sdaOut} == 2'b11, "R5 stop end levels", {sclOut, sdaOut}, 3);
            end
            3: begin
              chk(txCap == e.tx, "R6 write byte MSB first", txCap, e.tx);
              chk(rises == 9, "R6 write SCL rises", rises, 9);
              chk(edgeHi == 0, "R6 write SDA edges with SCL high", edgeHi, 0);
              chk(ackCap == 1'b1, "R6 SDA released on ack pulse", ackCap, 1);
              chk(ackSampled == e.ack, "R7 sampled ack", ackSampled, e.ack);
            end
            4: begin
              chk(rdData == e.rd, "R8 read byte", rdData, e.rd);
              chk(edgeHi == 0, "R8 read SDA edges with SCL high", edgeHi, 0);
              chk(rises == 9, "R8 read SCL rises", rises, 9);
              chk(ackCap == e.ackLvl, "R9 master ack level", ackCap, e.ackLvl);
              chk(ackSampled == e.ack, "R7 ack held over read", ackSampled, e.ack);
            end
            default: begin
              chk(lineChg == 0, "R3 unused code line changes", lineChg, 0);
            end
          endcase
        end
      end
    end
  end

  task automatic issue(input int op, input logic [7:0] data, input logic ackLvl,
                       input logic [7:0] slvByte, input logic slvAck);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp      = op[2:0];
    cmdData    = data;
    cmdAckLvl  = ackLvl;
    drvSlvByte = slvByte;
    drvSlvAck  = slvAck;
    cmdValid   = 1'b1;
    do @(negedge clk); while (!accSeen);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (sb.size() != 0 || !cmdReady) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sclOut && sdaOut, "R1 lines released in reset", {sclOut, sdaOut}, 3);
    chk(cmdReady && !done, "R1 ready in reset", {cmdReady, done}, 2);
    rstN = 1'b1;
    @(negedge clk);
    chk(sclOut && sdaOut && cmdReady && !done, "R1 state after reset",
        {sclOut, sdaOut, cmdReady, done}, 14);
    chk(ackSampled == 1'b1 && rdData == 8'd0, "R1 result outputs", {ackSampled, rdData}, 256);

    quarterDiv = 16'd3;
    issue(0, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(1, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(3, 8'hA5, 1'b1, 8'h00, 1'b0);  waitIdle();
    issue(3, 8'h3C, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(1, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(3, 8'h91, 1'b1, 8'h00, 1'b0);  waitIdle();
    issue(4, 8'h00, 1'b0, 8'hC3, 1'b1);  waitIdle();
    issue(4, 8'h00, 1'b1, 8'h5A, 1'b1);  waitIdle();
    issue(2, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(6, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();

    quarterDiv = 16'd6;
    issue(1, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(3, 8'h01, 1'b1, 8'h00, 1'b0);
    // R10: a request while busy must be ignored
    @(negedge clk);
    cmdOp = 3'd2;
    cmdValid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(cmdReady == 1'b0, "R10 ready low while busy", cmdReady, 0);
    end
    cmdValid = 1'b0;
    waitIdle();
    issue(4, 8'h00, 1'b0, 8'h80, 1'b1);  waitIdle();
    issue(4, 8'h00, 1'b1, 8'hFE, 1'b1);  waitIdle();
    issue(2, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(0, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    issue(5, 8'h00, 1'b1, 8'h00, 1'b1);  waitIdle();
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R10 no pending results", sb.size(), 0);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule